// File: doc/BRIEF.md
# Host Memory Window Interface

This block lets a host bus master reach an internal shared word memory through eight byte-wide I/O registers. The host has a plain synchronous byte port (write strobe, read strobe, 3-bit register offset, write byte, read byte). A host sets a word address and an access mode by writing two address bytes, then moves the bytes of that 32-bit word through four data byte registers. In the auto-increment mode, touching the highest data byte advances to the next word, so a long transfer can stream through the data registers without rewriting the address. A host may begin at any data byte to cover a start that is not word aligned.

Two further registers form a pair of one-byte mailboxes, one in each direction, each with a sticky full flag for the device side. The memory side is a word-addressed SRAM with one synchronous read port and one byte-enabled write port. The block fetches the addressed word whenever the address changes, so reads of data bytes always come back one cycle after the request. The byte address space is `ADDR_W` bits wide (9 to 15, default 15). Internal address 0 is the first byte of the shared region.

Top module: `hmw_top`

## Requirements
- R1: Register offsets are fixed: 0 host-to-device mailbox, 1 device-to-host mailbox, 2 address low byte, 3 address high byte, 4+n data byte n (n = 0..3). A host read returns the selected register on host_rdata one cycle after the request. If both strobes are high, the access is a write.
- R2: Address low byte: bits [1:0] set the mode (0 byte, 1 halfword, 2 word, 3 word with auto-increment) and bits [7:2] set byte-address bits [7:2]. Byte-address bits [1:0] are always zero. Reading offset 2 returns {word address bits [5:0], mode}.
- R3: Address high byte: bits [ADDR_W-9:0] set byte-address bits [ADDR_W-1:8]. All other bits, including bit 7, are ignored. Reading offset 3 returns those address bits, with zeros elsewhere.
- R4: A read of offset 4+n returns bits [8n+7:8n] of the memory word at the current word address.
- R5: A write of offset 4+n issues exactly one memory write to the current word. Only byte-enable bit n is set, with the byte in lane n. The other lanes of that word keep their contents.
- R6: In mode 3, a read or a write of data byte 3 advances the word address by one. The access itself uses the word in effect before the advance.
- R7: Accesses to data bytes 0 to 2 never change the address. In modes 0, 1 and 2, data byte 3 does not change it either, and every data byte still transfers in every mode.
- R8: An advance from the last word of the 2^ADDR_W byte space wraps to word 0.
- R9: Every address change fetches the new word at once. A data access in the very next cycle sees that word, including bytes written through the window earlier.
- R10: A host write to offset 0 stores the byte, shows it on dev_h2d_data and sets h2d_full. A dev_h2d_rd pulse clears h2d_full. A host write in the same cycle as the pulse leaves the flag set.
- R11: A dev_d2h_we pulse stores dev_d2h_wdata and sets d2h_full. A host read of offset 1 returns the byte and clears d2h_full. A device write in the same cycle as the read leaves the flag set.
- R12: After reset the address and mode are 0, both mailboxes and flags are 0, host_rdata is 0, and word 0 is fetched without any host action.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host write strobe |
| host_re | input | 1 | Host read strobe |
| host_off | input | 3 | Register offset within the window |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte, one cycle after the request |
| dev_h2d_rd | input | 1 | Device consumes the host-to-device mailbox |
| dev_h2d_data | output | 8 | Host-to-device mailbox contents |
| h2d_full | output | 1 | Host-to-device mailbox holds unread data |
| dev_d2h_we | input | 1 | Device writes the device-to-host mailbox |
| dev_d2h_wdata | input | 8 | Device-to-host mailbox byte |
| d2h_full | output | 1 | Device-to-host mailbox holds unread data |
| mem_re | output | 1 | SRAM read enable |
| mem_raddr | output | ADDR_W-2 | SRAM read word address |
| mem_rdata | input | 32 | SRAM read word, one cycle after mem_re |
| mem_we | output | 1 | SRAM write enable |
| mem_waddr | output | ADDR_W-2 | SRAM write word address |
| mem_be | output | 4 | SRAM byte enables |
| mem_wdata | output | 32 | SRAM write word, written byte replicated in all lanes |

## Verification
The assertions check the following properties on every cycle:
- each memory write has a single byte enable and comes only from a host data write;
- an address byte write always starts a fetch;
- lane 3 in mode 3 steps the word address by exactly one, and every other data access leaves the address alone;
- each mailbox flag rises after its writer acts and falls after a lone host read of offset 1.

Other behaviour can only be shown by the bench's scenarios. This covers the data returned per lane and the wrap from the last word to word 0. It also covers read-after-write on a refetched word, a start that is not word aligned, the ignored high-byte bits, and same-cycle set and clear on the mailbox flags. The bench sweeps every word of a small address space and computes each expected byte arithmetically.

// File: rtl/hmw_pkg.sv
package hmw_pkg;

  typedef enum logic [1:0] {
    MODE_B8      = 2'd0,
    MODE_B16     = 2'd1,
    MODE_B32     = 2'd2,
    MODE_B32_INC = 2'd3
  } acc_mode_e;

  localparam logic [2:0] OFF_H2D = 3'd0;
  localparam logic [2:0] OFF_D2H = 3'd1;
  localparam logic [2:0] OFF_ALO = 3'd2;
  localparam logic [2:0] OFF_AHI = 3'd3;
  localparam logic [1:0] TOP_LANE = 2'd3;

  // byte n of a word
  function automatic logic [7:0] lane_of(logic [31:0] w, logic [1:0] n);
    return w[8*n +: 8];
  endfunction

  // word with byte n replaced
  function automatic logic [31:0] lane_merge(logic [31:0] w, logic [1:0] n, logic [7:0] b);
    logic [31:0] r;
    r = w;
    r[8*n +: 8] = b;
    return r;
  endfunction

  function automatic logic [3:0] lane_be(logic [1:0] n);
    return 4'b0001 << n;
  endfunction

endpackage

// File: rtl/hmw_mailbox.sv
module hmw_mailbox (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic [7:0] wdata,
  input  logic       rd_clr,
  output logic [7:0] data,
  output logic       full
);
  logic [7:0] data_q;
  logic       full_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q <= '0;
      full_q <= 1'b0;
    end else begin
      if (wr) data_q <= wdata;
      // a write in the same cycle as the clear wins
      if (wr)          full_q <= 1'b1;
      else if (rd_clr) full_q <= 1'b0;
    end
  end

  assign data = data_q;
  assign full = full_q;
endmodule

// File: rtl/hmw_addr_reg.sv
module hmw_addr_reg
  import hmw_pkg::*;
#(
  parameter int ADDR_W = 15,
  localparam int WA = ADDR_W - 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_lo,
  input  logic          wr_hi,
  input  logic          step,
  input  logic [7:0]    wdata,
  output logic [WA-1:0] waddr,
  output logic [WA-1:0] waddr_nxt,
  output acc_mode_e     mode,
  output logic          chg,
  output logic [7:0]    lo_rb,
  output logic [7:0]    hi_rb
);
  localparam int LOW_W = 6;

  logic [WA-1:0] waddr_q, nxt;
  acc_mode_e     mode_q, mode_nxt;
  logic          inc_fire;

  function automatic logic [WA-1:0] set_low(logic [WA-1:0] a, logic [7:0] b);
    logic [WA-1:0] r;
    r = a;
    r[LOW_W-1:0] = b[7:2];
    return r;
  endfunction

  // high byte fills bits above the low six; excess bits drop off
  function automatic logic [WA-1:0] set_high(logic [WA-1:0] a, logic [7:0] b);
    return WA'((int'(b) % 128) * (1 << LOW_W) + int'(a[LOW_W-1:0]));
  endfunction

  function automatic logic [WA-1:0] step_word(logic [WA-1:0] a);
    return a + 1'b1;
  endfunction

  assign inc_fire = step && (mode_q == MODE_B32_INC);

  always_comb begin
    nxt      = waddr_q;
    mode_nxt = mode_q;
    if (wr_lo) begin
      nxt      = set_low(waddr_q, wdata);
      mode_nxt = acc_mode_e'(wdata[1:0]);
    end else if (wr_hi) begin
      nxt = set_high(waddr_q, wdata);
    end else if (inc_fire) begin
      nxt = step_word(waddr_q);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      waddr_q <= '0;
      mode_q  <= MODE_B8;
    end else begin
      waddr_q <= nxt;
      mode_q  <= mode_nxt;
    end
  end

  assign waddr     = waddr_q;
  assign waddr_nxt = nxt;
  assign mode      = mode_q;
  assign chg       = wr_lo | wr_hi | inc_fire;
  assign lo_rb     = {waddr_q[LOW_W-1:0], mode_q};
  assign hi_rb     = 8'(waddr_q >> LOW_W);
endmodule

// File: rtl/hmw_word_port.sv
module hmw_word_port
  import hmw_pkg::*;
#(
  parameter int WA = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lane_wr,
  input  logic [1:0]    lane,
  input  logic [7:0]    wdata,
  input  logic [WA-1:0] waddr,
  input  logic [WA-1:0] waddr_nxt,
  input  logic          chg,
  input  logic [31:0]   mem_rdata,
  output logic [31:0]   cur_word,
  output logic          mem_re,
  output logic [WA-1:0] mem_raddr,
  output logic          mem_we,
  output logic [WA-1:0] mem_waddr,
  output logic [3:0]    mem_be,
  output logic [31:0]   mem_wdata
);
  logic        boot_q;   // one fetch of word 0 out of reset
  logic        land_q;   // mem_rdata holds a fresh fetch this cycle
  logic [31:0] shadow_q; // coherent copy of the current word

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      boot_q   <= 1'b1;
      land_q   <= 1'b0;
      shadow_q <= '0;
    end else begin
      boot_q <= 1'b0;
      land_q <= chg | boot_q;
      if (lane_wr)     shadow_q <= lane_merge(cur_word, lane, wdata);
      else if (land_q) shadow_q <= mem_rdata;
    end
  end

  assign cur_word  = land_q ? mem_rdata : shadow_q;
  assign mem_re    = chg | boot_q;
  assign mem_raddr = chg ? waddr_nxt : waddr;
  assign mem_we    = lane_wr;
  assign mem_waddr = waddr;
  assign mem_be    = lane_be(lane);
  assign mem_wdata = {4{wdata}};
endmodule

// File: rtl/hmw_top.sv
module hmw_top
  import hmw_pkg::*;
#(
  parameter int ADDR_W = 15,
  localparam int WA = ADDR_W - 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_we,
  input  logic          host_re,
  input  logic [2:0]    host_off,
  input  logic [7:0]    host_wdata,
  output logic [7:0]    host_rdata,
  input  logic          dev_h2d_rd,
  output logic [7:0]    dev_h2d_data,
  output logic          h2d_full,
  input  logic          dev_d2h_we,
  input  logic [7:0]    dev_d2h_wdata,
  output logic          d2h_full,
  output logic          mem_re,
  output logic [WA-1:0] mem_raddr,
  input  logic [31:0]   mem_rdata,
  output logic          mem_we,
  output logic [WA-1:0] mem_waddr,
  output logic [3:0]    mem_be,
  output logic [31:0]   mem_wdata
);
  // decoded host events, named for the checker
  logic          host_rd, is_data, lane_wr, lane_step, addr_chg;
  logic          wr_lo, wr_hi, wr_h2d, rd_d2h;
  logic [1:0]    lane;
  logic [WA-1:0] cur_waddr, nxt_waddr;
  acc_mode_e     addr_mode;
  logic [7:0]    lo_rb, hi_rb, d2h_data;
  logic [31:0]   cur_word;
  logic [7:0]    rdata_q, rdata_mux;

  assign host_rd   = host_re & ~host_we;
  assign is_data   = host_off[2];
  assign lane      = host_off[1:0];
  assign lane_wr   = host_we & is_data;
  assign lane_step = (host_we | host_rd) & is_data & (lane == TOP_LANE);
  assign wr_lo     = host_we & (host_off == OFF_ALO);
  assign wr_hi     = host_we & (host_off == OFF_AHI);
  assign wr_h2d    = host_we & (host_off == OFF_H2D);
  assign rd_d2h    = host_rd & (host_off == OFF_D2H);

  hmw_addr_reg #(.ADDR_W(ADDR_W)) u_addr (
    .clk, .rst_n,
    .wr_lo, .wr_hi,
    .step      (lane_step),
    .wdata     (host_wdata),
    .waddr     (cur_waddr),
    .waddr_nxt (nxt_waddr),
    .mode      (addr_mode),
    .chg       (addr_chg),
    .lo_rb, .hi_rb
  );

  hmw_word_port #(.WA(WA)) u_word (
    .clk, .rst_n,
    .lane_wr, .lane,
    .wdata     (host_wdata),
    .waddr     (cur_waddr),
    .waddr_nxt (nxt_waddr),
    .chg       (addr_chg),
    .mem_rdata, .cur_word,
    .mem_re, .mem_raddr, .mem_we, .mem_waddr, .mem_be, .mem_wdata
  );

  hmw_mailbox u_h2d (
    .clk, .rst_n,
    .wr     (wr_h2d),
    .wdata  (host_wdata),
    .rd_clr (dev_h2d_rd),
    .data   (dev_h2d_data),
    .full   (h2d_full)
  );

  hmw_mailbox u_d2h (
    .clk, .rst_n,
    .wr     (dev_d2h_we),
    .wdata  (dev_d2h_wdata),
    .rd_clr (rd_d2h),
    .data   (d2h_data),
    .full   (d2h_full)
  );

  always_comb begin
    unique case (host_off)
      OFF_H2D: rdata_mux = dev_h2d_data;
      OFF_D2H: rdata_mux = d2h_data;
      OFF_ALO: rdata_mux = lo_rb;
      OFF_AHI: rdata_mux = hi_rb;
      default: rdata_mux = lane_of(cur_word, lane);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       rdata_q <= '0;
    else if (host_rd) rdata_q <= rdata_mux;
  end

  assign host_rdata = rdata_q;
endmodule

// File: rtl/hmw_chk.sv
module hmw_chk #(
  parameter int WA = 13
) (
  input logic          clk,
  input logic          rst_n,
  input logic          host_we,
  input logic          host_re,
  input logic [2:0]    host_off,
  input logic [WA-1:0] cur_waddr,
  input logic [1:0]    addr_mode,
  input logic          mem_re,
  input logic          mem_we,
  input logic [3:0]    mem_be,
  input logic          h2d_full,
  input logic          d2h_full,
  input logic          dev_d2h_we
);
  logic          acc;
  logic [WA-1:0] inc_w;
  assign acc   = host_we | host_re;
  assign inc_w = cur_waddr + 1'b1;

  // R5
  be_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> $countones(mem_be) == 1);

  // R5
  we_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (host_we && host_off[2]));

  // R9
  fetch_on_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_we && host_off[2:1] == 2'b01) |-> mem_re);

  // R6
  auto_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && host_off == 3'd7 && addr_mode == 2'd3) |=> cur_waddr == $past(inc_w));

  // R7
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && host_off[2] && (host_off[1:0] != 2'd3 || addr_mode != 2'd3)) |=> $stable(cur_waddr));

  // R10
  h2d_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_we && host_off == 3'd0) |=> h2d_full);

  // R11
  d2h_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dev_d2h_we |=> d2h_full);

  // R11
  d2h_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_re && !host_we && host_off == 3'd1 && !dev_d2h_we) |=> !d2h_full);
endmodule

bind hmw_top hmw_chk #(.WA(WA)) u_chk (.*);

// File: tb/tb_hmw_top.sv
module tb_hmw_top;
  localparam int AW = 10;
  localparam int WA = AW - 2;
  localparam int NW = 1 << WA;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          host_we = 1'b0, host_re = 1'b0;
  logic [2:0]    host_off = '0;
  logic [7:0]    host_wdata = '0;
  logic [7:0]    host_rdata;
  logic          dev_h2d_rd = 1'b0;
  logic [7:0]    dev_h2d_data;
  logic          h2d_full;
  logic          dev_d2h_we = 1'b0;
  logic [7:0]    dev_d2h_wdata = '0;
  logic          d2h_full;
  logic          mem_re, mem_we;
  logic [WA-1:0] mem_raddr, mem_waddr;
  logic [31:0]   mem_rdata, mem_wdata;
  logic [3:0]    mem_be;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  hmw_top #(.ADDR_W(AW)) dut (.*);

  function automatic logic [31:0] pat(int i);
    logic [7:0] b;
    b = 8'(i);
    return {b ^ 8'h3C, b + 8'd17, ~b, b};
  endfunction

  // SRAM model: loaded during reset, sync read, byte-enable write
  logic [31:0] sram [NW];
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NW; i++) sram[i] <= pat(i);
    end else begin
      for (int k = 0; k < 4; k++)
        if (mem_we && mem_be[k]) sram[mem_waddr][8*k +: 8] <= mem_wdata[8*k +: 8];
      if (mem_re) mem_rdata <= sram[mem_raddr];
    end
  end

  // bench-side expectations
  logic [31:0] exp_m [NW];
  int e_w = 0;
  int e_mode = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic model(bit wr, int off, int d);
    if (off >= 4) begin
      if (wr) exp_m[e_w][8*(off-4) +: 8] = 8'(d);
      if (off == 7 && e_mode == 3) e_w = (e_w + 1) % NW;
    end else if (wr && off == 2) begin
      e_mode = d % 4;
      e_w = (e_w / 64) * 64 + d / 4;
    end else if (wr && off == 3) begin
      e_w = (e_w % 64) + (d % (NW / 64)) * 64;
    end
  endtask

  task automatic hw(int off, int d);
    host_we = 1'b1; host_off = 3'(off); host_wdata = 8'(d);
    @(negedge clk);
    host_we = 1'b0;
    model(1, off, d);
  endtask

  task automatic hr(int off, output logic [7:0] d);
    host_re = 1'b1; host_off = 3'(off);
    @(negedge clk);
    host_re = 1'b0;
    d = host_rdata;
    model(0, off, 0);
  endtask

  task automatic dread(int l, string req);
    logic [7:0] d, e;
    e = exp_m[e_w][8*l +: 8];
    hr(4 + l, d);
    chk(req, {24'h0, d}, {24'h0, e});
  endtask

  task automatic set_addr(int w, int mode);
    hw(3, w / 64);
    hw(2, (w % 64) * 4 + mode);
  endtask

  logic [7:0] rd;

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired, run incomplete (R12)");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < NW; i++) exp_m[i] = pat(i);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);

    // R12 reset state
    chk("R12 rdata", {24'h0, host_rdata}, 32'h0);
    chk("R12 h2d_full", {31'h0, h2d_full}, 32'h0);
    chk("R12 d2h_full", {31'h0, d2h_full}, 32'h0);
    chk("R12 h2d data", {24'h0, dev_h2d_data}, 32'h0);
    hr(2, rd); chk("R12 addr lo", {24'h0, rd}, 32'h0);
    hr(3, rd); chk("R12 addr hi", {24'h0, rd}, 32'h0);
    dread(0, "R12 word0 fetched");

    // R2 R3 address bytes and readback
    hw(2, 8'hB6);
    hr(2, rd); chk("R2 lo readback", {24'h0, rd}, 32'hB6);
    hw(3, 8'hFD);
    hr(3, rd); chk("R3 hi ignored bits", {24'h0, rd}, 32'h01);
    hr(2, rd); chk("R3 lo kept", {24'h0, rd}, 32'hB6);
    chk("R3 model word", e_w, 109);
    for (int l = 0; l < 4; l++) dread(l, "R4 R9 word after addr change");
    hr(2, rd); chk("R7 mode2 no step", {24'h0, rd}, 32'hB6);

    // R4 R6 R8 full sweep with auto-increment
    set_addr(0, 3);
    for (int w = 0; w < NW; w++)
      for (int l = 0; l < 4; l++) dread(l, "R4 R6 sweep");
    hr(2, rd); chk("R8 wrap lo", {24'h0, rd}, 32'h03);
    hr(3, rd); chk("R8 wrap hi", {24'h0, rd}, 32'h00);

    // R7 misaligned start
    set_addr(5, 3);
    dread(2, "R7 misaligned lane2");
    dread(3, "R7 misaligned lane3");
    dread(0, "R6 next word lane0");
    dread(1, "R7 next word lane1");
    hr(2, rd); chk("R6 addr after step", {24'h0, rd}, 32'h1B);

    // R7 modes 0 and 1 never step, all lanes transfer
    for (int m = 0; m < 2; m++) begin
      set_addr(20, m);
      dread(3, "R7 narrow mode lane3");
      dread(3, "R7 narrow mode lane3 again");
      dread(0, "R7 narrow mode lane0");
      hr(2, rd); chk("R7 narrow mode addr", {24'h0, rd}, 32'(20 * 4 + m));
    end
    hw(7, 8'hE1);
    dread(3, "R5 R7 lane3 write mode1");
    hr(2, rd); chk("R7 write no step", {24'h0, rd}, 32'(20 * 4 + 1));

    // R5 R9 byte write and read-after-write
    set_addr(30, 2);
    hw(5, 8'h77);
    for (int l = 0; l < 4; l++) dread(l, "R5 single lane write");
    hw(4, 8'h9A);
    dread(0, "R9 read after write");
    set_addr(31, 2);
    set_addr(30, 2);
    for (int l = 0; l < 4; l++) dread(l, "R9 refetch after write");

    // R5 R6 R8 write stream across the top of the space
    set_addr(NW - 6, 3);
    for (int k = 0; k < 40; k++) hw(4 + k % 4, k * 7 + 1);
    chk("R8 write stream addr", e_w, 4);
    set_addr(0, 3);
    for (int w = 0; w < NW; w++)
      for (int l = 0; l < 4; l++) dread(l, "R5 R8 memory image");

    // R10 host-to-device mailbox
    hw(0, 8'h5A);
    chk("R10 h2d full", {31'h0, h2d_full}, 32'h1);
    chk("R10 h2d data", {24'h0, dev_h2d_data}, 32'h5A);
    hr(0, rd); chk("R1 h2d readback", {24'h0, rd}, 32'h5A);
    dev_h2d_rd = 1'b1; @(negedge clk); dev_h2d_rd = 1'b0;
    chk("R10 h2d cleared", {31'h0, h2d_full}, 32'h0);
    dev_h2d_rd = 1'b1;
    hw(0, 8'h11);
    dev_h2d_rd = 1'b0;
    chk("R10 set wins", {31'h0, h2d_full}, 32'h1);
    chk("R10 new data", {24'h0, dev_h2d_data}, 32'h11);

    // R11 device-to-host mailbox
    dev_d2h_we = 1'b1; dev_d2h_wdata = 8'h3C;
    @(negedge clk); dev_d2h_we = 1'b0;
    chk("R11 d2h full", {31'h0, d2h_full}, 32'h1);
    hr(1, rd); chk("R11 d2h read", {24'h0, rd}, 32'h3C);
    chk("R11 d2h cleared", {31'h0, d2h_full}, 32'h0);
    dev_d2h_we = 1'b1; dev_d2h_wdata = 8'h44;
    hr(1, rd);
    dev_d2h_we = 1'b0;
    chk("R11 old byte on collision", {24'h0, rd}, 32'h3C);
    chk("R11 set wins", {31'h0, d2h_full}, 32'h1);
    hr(1, rd); chk("R11 new byte", {24'h0, rd}, 32'h44);
    chk("R10 h2d untouched", {31'h0, h2d_full}, 32'h1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule